// File: doc/BRIEF.md
# Next-Node Key Lookup Table

This block maps a short protocol key, such as the protocol number taken from a network header, to the address of the parse node that handles that protocol. It holds a small table of entries. Each entry has a valid flag, a key and a target address, and a configuration port writes the entries one at a time. A lookup port presents a key and receives, one cycle later, the address to load into the parser's next-node register.

A lookup always produces an address. When no valid entry matches, the result is one of two handler addresses that are supplied on input ports. The per-lookup "next protocol required" flag selects between them. With the flag set, the failure handler is used, because a missing protocol is an error. With the flag clear, the success handler is used, because the parse may legitimately end here.

A lookup can also carry a stop flag. In that case the block raises a jump request together with the result, and the target of that jump is the new next-node value. When several entries match, the entry with the lowest index wins. A configuration write made in the same cycle as a lookup is visible only to later lookups.

Top module: `nxt_node_cam`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `done_o`, `jump_o` and `hit_o` are 0 and `nxt_o` is 0.
- R2: A lookup whose key equals the key of a valid entry gives, in the cycle after the request, `done_o`=1, `hit_o`=1, `nxt_o` equal to that entry's target, and `hit_idx_o` equal to its index.
- R3: A lookup that matches no valid entry gives, in the cycle after the request, `done_o`=1 and `hit_o`=0. `nxt_o` is `fail_addr_i` if `lk_need_next_i` was 1 in the request cycle, and `okay_addr_i` if it was 0.
- R4: When several valid entries hold the requested key, the one with the lowest index supplies `nxt_o` and `hit_idx_o`.
- R5: An entry written with the valid bit at 0 never matches, whatever its key.
- R6: `jump_o` is 1 exactly in the cycle after a request that had `lk_stop_i`=1, and the jump target is the `nxt_o` shown in that cycle. After any other cycle `jump_o` is 0.
- R7: `done_o` is 1 only in the cycle after a request. Without a request, `nxt_o`, `hit_o` and `hit_idx_o` keep their last values.
- R8: A configuration write in the same cycle as a lookup does not affect that lookup. It affects lookups from the next cycle on.
- R9: A key matches only when all 8 bits are equal. For example, key 0x86 does not match an entry holding 0x06.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write one table entry |
| cfg_idx_i | input | 4 | Index of the entry to write |
| cfg_valid_i | input | 1 | Valid bit to store |
| cfg_key_i | input | 8 | Key to store |
| cfg_target_i | input | 32 | Target address to store |
| okay_addr_i | input | 32 | Success handler address, used on a miss when no next protocol is required |
| fail_addr_i | input | 32 | Failure handler address, used on a miss when a next protocol is required |
| lk_req_i | input | 1 | Lookup request |
| lk_key_i | input | 8 | Lookup key |
| lk_need_next_i | input | 1 | 1 if a next protocol is mandatory |
| lk_stop_i | input | 1 | Stop-node lookup: request a jump |
| nxt_o | output | 32 | Next-node address |
| done_o | output | 1 | Result-valid pulse |
| hit_o | output | 1 | Last lookup matched an entry |
| hit_idx_o | output | 4 | Index of the matching entry |
| jump_o | output | 1 | Jump request to `nxt_o` |

## Verification
All results of a lookup are due exactly one clock after the request edge: `done_o`, `jump_o`, `hit_o`, `hit_idx_o` and `nxt_o` all come from a single register stage. A configuration write only changes table state, which the next request edge reads. The bench applies each cycle's inputs at the falling edge. It computes the expected outputs from its own copy of the table, and only after that does it apply that cycle's write to the model. It compares every output at the following falling edge, one full register stage after the request. Cycles without a request are also compared, so held values and the absence of `done_o` are checked.

// File: rtl/nnc_pkg.sv
package nnc_pkg;
    localparam int unsigned NNC_ENTRIES = 16;
    localparam int unsigned NNC_KEY_W   = 8;
    localparam int unsigned NNC_ADDR_W  = 32;

    typedef enum logic [1:0] {
        OUTC_NONE,
        OUTC_HIT,
        OUTC_MISS_OKAY,
        OUTC_MISS_FAIL
    } outcome_e;
endpackage

// File: rtl/nnc_table.sv
module nnc_table #(
    parameter int unsigned ENTRIES = nnc_pkg::NNC_ENTRIES,
    parameter int unsigned KEY_W   = nnc_pkg::NNC_KEY_W,
    parameter int unsigned ADDR_W  = nnc_pkg::NNC_ADDR_W,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic                             we_i,
    input  logic [IDX_W-1:0]                 idx_i,
    input  logic                             valid_i,
    input  logic [KEY_W-1:0]                 key_i,
    input  logic [ADDR_W-1:0]                target_i,
    output logic [ENTRIES-1:0]               valid_o,
    output logic [ENTRIES-1:0][KEY_W-1:0]    key_o,
    output logic [ENTRIES-1:0][ADDR_W-1:0]   target_o
);
    typedef struct packed {
        logic [ENTRIES-1:0]             valid;
        logic [ENTRIES-1:0][KEY_W-1:0]  key;
        logic [ENTRIES-1:0][ADDR_W-1:0] target;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (we_i) begin
            tbl_d.valid[idx_i]  = valid_i;
            tbl_d.key[idx_i]    = key_i;
            tbl_d.target[idx_i] = target_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign valid_o  = tbl_q.valid;
    assign key_o    = tbl_q.key;
    assign target_o = tbl_q.target;
endmodule

// File: rtl/nnc_match.sv
module nnc_match #(
    parameter int unsigned ENTRIES = nnc_pkg::NNC_ENTRIES,
    parameter int unsigned KEY_W   = nnc_pkg::NNC_KEY_W
) (
    input  logic [ENTRIES-1:0]            valid_i,
    input  logic [ENTRIES-1:0][KEY_W-1:0] key_i,
    input  logic [KEY_W-1:0]              probe_i,
    output logic [ENTRIES-1:0]            match_o
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_o[g] = valid_i[g] && (key_i[g] == probe_i);
    end
endmodule

// File: rtl/nnc_prio.sv
module nnc_prio #(
    parameter int unsigned ENTRIES = nnc_pkg::NNC_ENTRIES,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] req_i,
    output logic               any_o,
    output logic [IDX_W-1:0]   idx_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/nxt_node_cam.sv
module nxt_node_cam #(
    parameter int unsigned ENTRIES = nnc_pkg::NNC_ENTRIES,
    parameter int unsigned KEY_W   = nnc_pkg::NNC_KEY_W,
    parameter int unsigned ADDR_W  = nnc_pkg::NNC_ADDR_W,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cfg_we_i,
    input  logic [IDX_W-1:0]  cfg_idx_i,
    input  logic              cfg_valid_i,
    input  logic [KEY_W-1:0]  cfg_key_i,
    input  logic [ADDR_W-1:0] cfg_target_i,
    input  logic [ADDR_W-1:0] okay_addr_i,
    input  logic [ADDR_W-1:0] fail_addr_i,
    input  logic              lk_req_i,
    input  logic [KEY_W-1:0]  lk_key_i,
    input  logic              lk_need_next_i,
    input  logic              lk_stop_i,
    output logic [ADDR_W-1:0] nxt_o,
    output logic              done_o,
    output logic              hit_o,
    output logic [IDX_W-1:0]  hit_idx_o,
    output logic              jump_o
);
    import nnc_pkg::*;

    typedef struct packed {
        logic              done;
        logic              jump;
        logic              hit;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] nxt;
    } res_t;

    logic [ENTRIES-1:0]             ent_valid;
    logic [ENTRIES-1:0][KEY_W-1:0]  ent_key;
    logic [ENTRIES-1:0][ADDR_W-1:0] ent_target;
    logic [ENTRIES-1:0]             match_vec;
    logic                           any_hit;
    logic [IDX_W-1:0]               win_idx;
    outcome_e                       outc;
    res_t                           res_d, res_q;

    nnc_table #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .ADDR_W(ADDR_W)) u_table (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (cfg_we_i),
        .idx_i    (cfg_idx_i),
        .valid_i  (cfg_valid_i),
        .key_i    (cfg_key_i),
        .target_i (cfg_target_i),
        .valid_o  (ent_valid),
        .key_o    (ent_key),
        .target_o (ent_target)
    );

    nnc_match #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_match (
        .valid_i (ent_valid),
        .key_i   (ent_key),
        .probe_i (lk_key_i),
        .match_o (match_vec)
    );

    nnc_prio #(.ENTRIES(ENTRIES)) u_prio (
        .req_i (match_vec),
        .any_o (any_hit),
        .idx_o (win_idx)
    );

    always_comb begin
        if (!lk_req_i)           outc = OUTC_NONE;
        else if (any_hit)        outc = OUTC_HIT;
        else if (lk_need_next_i) outc = OUTC_MISS_FAIL;
        else                     outc = OUTC_MISS_OKAY;
    end

    always_comb begin
        res_d      = res_q;
        res_d.done = 1'b0;
        res_d.jump = 1'b0;
        unique case (outc)
            OUTC_HIT: begin
                res_d.hit = 1'b1;
                res_d.idx = win_idx;
                res_d.nxt = ent_target[win_idx];
            end
            OUTC_MISS_FAIL: begin
                res_d.hit = 1'b0;
                res_d.idx = '0;
                res_d.nxt = fail_addr_i;
            end
            OUTC_MISS_OKAY: begin
                res_d.hit = 1'b0;
                res_d.idx = '0;
                res_d.nxt = okay_addr_i;
            end
            default: ;
        endcase
        if (outc != OUTC_NONE) begin
            res_d.done = 1'b1;
            res_d.jump = lk_stop_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign nxt_o     = res_q.nxt;
    assign done_o    = res_q.done;
    assign hit_o     = res_q.hit;
    assign hit_idx_o = res_q.idx;
    assign jump_o    = res_q.jump;
endmodule

// File: rtl/nnc_checker.sv
module nnc_checker #(
    parameter int unsigned ENTRIES = nnc_pkg::NNC_ENTRIES,
    parameter int unsigned ADDR_W  = nnc_pkg::NNC_ADDR_W,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               lk_req_i,
    input logic               lk_need_next_i,
    input logic               lk_stop_i,
    input logic [ADDR_W-1:0]  okay_addr_i,
    input logic [ADDR_W-1:0]  fail_addr_i,
    input logic [ENTRIES-1:0] match_vec,
    input logic [ADDR_W-1:0]  nxt_o,
    input logic               done_o,
    input logic               hit_o,
    input logic [IDX_W-1:0]   hit_idx_o,
    input logic               jump_o
);
    logic [ENTRIES-1:0] mv_q;
    logic [ENTRIES-1:0] below_mask;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mv_q <= '0;
        else         mv_q <= match_vec;
    end

    always_comb begin
        below_mask = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (i < int'(hit_idx_o)) below_mask[i] = 1'b1;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (!done_o && !jump_o && !hit_o));

    p_hit_has_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && hit_o) |-> mv_q[hit_idx_o]);

    p_miss_handler_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lk_req_i |=> (hit_o || nxt_o == ($past(lk_need_next_i) ? $past(fail_addr_i) : $past(okay_addr_i))));

    p_lowest_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && hit_o) |-> ((mv_q & below_mask) == '0));

    p_jump_on_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lk_req_i && lk_stop_i) |=> jump_o);

    p_jump_needs_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        jump_o |-> done_o);

    p_done_after_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lk_req_i |=> done_o);

    p_idle_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lk_req_i |=> (!done_o && $stable(nxt_o) && $stable(hit_o) && $stable(hit_idx_o)));
endmodule

bind nxt_node_cam nnc_checker #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_nnc_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .lk_req_i       (lk_req_i),
    .lk_need_next_i (lk_need_next_i),
    .lk_stop_i      (lk_stop_i),
    .okay_addr_i    (okay_addr_i),
    .fail_addr_i    (fail_addr_i),
    .match_vec      (match_vec),
    .nxt_o          (nxt_o),
    .done_o         (done_o),
    .hit_o          (hit_o),
    .hit_idx_o      (hit_idx_o),
    .jump_o         (jump_o)
);

// File: tb/nxt_node_cam_tb_top.sv
module nxt_node_cam_tb_top;
    localparam int N = 16;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [3:0]  cfg_idx_i = '0;
    logic        cfg_valid_i = 1'b0;
    logic [7:0]  cfg_key_i = '0;
    logic [31:0] cfg_target_i = '0;
    logic [31:0] okay_addr_i = 32'h0000_A000;
    logic [31:0] fail_addr_i = 32'h0000_E000;
    logic        lk_req_i = 1'b0;
    logic [7:0]  lk_key_i = '0;
    logic        lk_need_next_i = 1'b0;
    logic        lk_stop_i = 1'b0;
    logic [31:0] nxt_o;
    logic        done_o, hit_o, jump_o;
    logic [3:0]  hit_idx_o;

    always #2 clk_i = ~clk_i;

    nxt_node_cam dut_i (
        .clk_i, .rst_ni, .cfg_we_i, .cfg_idx_i, .cfg_valid_i, .cfg_key_i,
        .cfg_target_i, .okay_addr_i, .fail_addr_i, .lk_req_i, .lk_key_i,
        .lk_need_next_i, .lk_stop_i, .nxt_o, .done_o, .hit_o, .hit_idx_o, .jump_o
    );

    // behavioural model state
    bit          m_valid [N];
    logic [7:0]  m_key   [N];
    logic [31:0] m_tgt   [N];
    logic [31:0] e_nxt = '0;
    logic        e_hit = 1'b0;
    logic [3:0]  e_idx = '0;
    logic        e_done = 1'b0;
    logic        e_jump = 1'b0;
    int vectors = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [31:0] lfsr = 32'hACE1_2468;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one cycle: drive at negedge, model, then compare at next negedge
    task automatic step(input bit we, input int idx, input bit vld, input logic [7:0] key,
                        input logic [31:0] tgt, input bit req, input logic [7:0] lkey,
                        input bit need, input bit stop, input string tag);
        cfg_we_i = we; cfg_idx_i = 4'(idx); cfg_valid_i = vld; cfg_key_i = key; cfg_target_i = tgt;
        lk_req_i = req; lk_key_i = lkey; lk_need_next_i = need; lk_stop_i = stop;
        e_done = req;
        e_jump = req && stop;
        if (req) begin
            int w;
            w = -1;
            for (int i = 0; i < N; i++)
                if (w < 0 && m_valid[i] && m_key[i] == lkey) w = i;
            if (w >= 0) begin
                e_hit = 1'b1; e_idx = 4'(w); e_nxt = m_tgt[w];
            end else begin
                e_hit = 1'b0; e_idx = '0; e_nxt = need ? fail_addr_i : okay_addr_i;
            end
        end
        if (we) begin
            m_valid[idx] = vld; m_key[idx] = key; m_tgt[idx] = tgt;
        end
        @(posedge clk_i);
        @(negedge clk_i);
        chk(req ? "R7" : "R7", "done_o", 32'(done_o), 32'(e_done));
        chk("R6", "jump_o", 32'(jump_o), 32'(e_jump));
        chk(tag, "nxt_o", nxt_o, e_nxt);
        chk(tag, "hit_o", 32'(hit_o), 32'(e_hit));
        chk(tag, "hit_idx_o", 32'(hit_idx_o), 32'(e_idx));
    endtask

    task automatic wr(input int idx, input bit vld, input logic [7:0] key, input logic [31:0] tgt);
        step(1'b1, idx, vld, key, tgt, 1'b0, 8'h00, 1'b0, 1'b0, "R7");
    endtask

    task automatic lk(input logic [7:0] key, input bit need, input bit stop, input string tag);
        step(1'b0, 0, 1'b0, 8'h00, 32'h0, 1'b1, key, need, stop, tag);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_valid[i] = 0; m_key[i] = '0; m_tgt[i] = '0; end
        repeat (3) @(negedge clk_i);
        // R1: outputs quiet during reset
        chk("R1", "done_o in reset", 32'(done_o), 32'd0);
        chk("R1", "nxt_o in reset", nxt_o, 32'd0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        chk("R1", "done_o after reset", 32'(done_o), 32'd0);
        chk("R1", "jump_o after reset", 32'(jump_o), 32'd0);
        chk("R1", "hit_o after reset", 32'(hit_o), 32'd0);

        // empty table: both miss handlers (R3)
        lk(8'h06, 1'b1, 1'b0, "R3");
        lk(8'h06, 1'b0, 1'b0, "R3");

        wr(0, 1'b1, 8'h06, 32'h0000_1000);
        wr(1, 1'b1, 8'h11, 32'h0000_2000);
        wr(3, 1'b0, 8'h41, 32'h0000_3000);   // stored invalid (R5)
        wr(5, 1'b1, 8'h06, 32'h0000_5000);   // duplicate key (R4)
        wr(15, 1'b1, 8'hFF, 32'h0000_F000);

        lk(8'h11, 1'b1, 1'b0, "R2");
        lk(8'h06, 1'b1, 1'b0, "R4");
        lk(8'h41, 1'b1, 1'b0, "R5");
        lk(8'h41, 1'b0, 1'b0, "R5");
        lk(8'hFF, 1'b0, 1'b1, "R6");
        lk(8'h99, 1'b0, 1'b1, "R6");
        lk(8'h86, 1'b1, 1'b0, "R9");
        lk(8'h07, 1'b0, 1'b0, "R9");
        // idle cycles hold last result (R7)
        step(1'b0, 0, 1'b0, 8'h00, 32'h0, 1'b0, 8'h11, 1'b1, 1'b1, "R7");
        step(1'b0, 0, 1'b0, 8'h00, 32'h0, 1'b0, 8'h06, 1'b0, 1'b0, "R7");
        // R8: invalidate entry 0 in the same cycle as a lookup of its key
        step(1'b1, 0, 1'b0, 8'h06, 32'h0, 1'b1, 8'h06, 1'b1, 1'b0, "R8");
        lk(8'h06, 1'b1, 1'b0, "R8");
        // R8: new key written and looked up together misses, then hits
        step(1'b1, 7, 1'b1, 8'h2F, 32'h0000_7000, 1'b1, 8'h2F, 1'b1, 1'b1, "R8");
        lk(8'h2F, 1'b1, 1'b0, "R8");
        // handler address change is sampled in the request cycle (R3)
        okay_addr_i = 32'h0000_B0B0;
        lk(8'h55, 1'b0, 1'b0, "R3");

        // mixed pseudo-random traffic over a small key space (R2, R4)
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[0], int'(lfsr[7:4]), lfsr[8] | lfsr[9], {5'b0, lfsr[12:10]},
                 {16'h0, lfsr[31:16]}, lfsr[13], {5'b0, lfsr[17:15]}, lfsr[18], lfsr[19],
                 "R2");
        end

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule